// File: doc/BRIEF.md
# Operand-Waiting Station Array with Result-Bus Wakeup

This block keeps issued operations parked until both of their source operands exist. Every entry carries an operation code, two operand values, two producer tags, an address/immediate field and an occupancy flag. An operand can arrive at issue in one of two forms. It can be an actual value, with a producer tag of zero. It can also be the tag of the station that will eventually compute it.

In every cycle, each entry compares its pending tags against the one shared result bus. On a match, the entry latches the broadcast value and clears the tag. An entry whose two tags are both zero is eligible to start. Each cycle the oldest eligible entry is sent to a latency-modelled execution placeholder. When its countdown expires, the entry requests the result bus, and the oldest finished entry gets it. A station is released only at the end of the cycle in which its own result appears on the bus. The bus output is meant to be looped back to the snoop input, together with results from producers outside the array.

Top module: `rs_array`

## Requirements
- R1: After reset, every entry is empty. `issue_ready_o` is 1, `issue_tag_o` equals `BASE_TAG` (default 1) and `res_valid_o` is 0.
- R2: An issue goes to the lowest-numbered empty entry. `issue_tag_o` shows that entry's tag before the issue, and entry i has tag `BASE_TAG + i`. The same tag is later used when the entry broadcasts.
- R3: When every entry is occupied, `issue_ready_o` is 0 and an issue request is ignored. The ignored request never produces a broadcast.
- R4: Suppose an operation is issued in cycle t with both producer tags at zero. It begins executing in cycle t+1 and its result is on the bus in cycle t+1+L, where L is its latency.
- R5: Op codes and latencies are as follows. 0 is add (2 cycles). 1 is subtract (2 cycles). 2 is multiply, keeping the low 16 bits (10 cycles). 3 is divide vj/vk (40 cycles), and it gives all ones when vk is 0. 4 is address compute vj + A (1 cycle), with vk ignored. Codes 5 to 7 behave as add.
- R6: A waiting entry latches the bus data into the operand whose nonzero tag matches `bus_tag_i` while `bus_valid_i` is set, and clears that tag. Execution can start no earlier than the following cycle.
- R7: If an operand tag is written at issue in the same cycle that the bus broadcasts that tag, the value is captured and the wakeup is not lost.
- R8: At most one entry starts executing per cycle. Among the ready entries, the one issued earliest starts first, whatever its index.
- R9: At most one result is broadcast per cycle. When several entries finish together, the earliest-issued one is broadcast and the others keep their results for later cycles.
- R10: An entry becomes empty at the end of the cycle in which its result is broadcast. In the next cycle it can accept an issue again.
- R11: A bus broadcast with tag 0 never changes a stored operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_valid_i | input | 1 | Issue request |
| issue_op_i | input | 3 | Operation code (see R5) |
| issue_vj_i | input | DATA_W | First operand value |
| issue_vk_i | input | DATA_W | Second operand value |
| issue_qj_i | input | TAG_W | First operand producer tag, 0 = value valid |
| issue_qk_i | input | TAG_W | Second operand producer tag, 0 = value valid |
| issue_addr_i | input | DATA_W | Address/immediate field |
| issue_ready_o | output | 1 | An entry is free |
| issue_tag_o | output | TAG_W | Tag the next issue will receive |
| bus_valid_i | input | 1 | Snooped result bus valid |
| bus_tag_i | input | TAG_W | Snooped result bus producer tag |
| bus_data_i | input | DATA_W | Snooped result bus value |
| res_valid_o | output | 1 | This array broadcasts a result |
| res_tag_o | output | TAG_W | Tag of the broadcasting entry |
| res_data_o | output | DATA_W | Broadcast result value |

## Verification
The assertions rely on three assumptions about the inputs. The snoop bus carries at most one producer per cycle. An issued operand tag names either a station of this array that is still occupied or a producer outside the array, never the entry being written. The bench satisfies the first assumption by looping `res_*_o` back onto the snoop bus and injecting outside tags (tag 9, plus tag 0 for R11) only in cycles when no local result is due. It satisfies the second by choosing its producer tags from that set. Ordering is tested by first freeing a lower-indexed entry and then refilling it after a higher-indexed one. This makes age order differ from index order, and a collision of two finished entries then shows which one the bus goes to.

// File: rtl/rs_pkg.sv
`timescale 1ns/1ps
package rs_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_MUL = 3'd2,
    OP_DIV = 3'd3,
    OP_ADR = 3'd4
  } rs_op_e;

  typedef enum logic [1:0] {
    ST_FREE,
    ST_WAIT,
    ST_EXEC,
    ST_DONE
  } rs_state_e;
endpackage

// File: rtl/rs_age_pick.sv
`timescale 1ns/1ps
// older_i[j][i] set: entry j was issued before entry i
module rs_age_pick #(
  parameter int N = 3
) (
  input  logic [N-1:0]        req_i,
  input  logic [N-1:0][N-1:0] older_i,
  output logic [N-1:0]        gnt_o
);
  always_comb begin
    for (int i = 0; i < N; i++) begin
      gnt_o[i] = req_i[i];
      for (int j = 0; j < N; j++) begin
        if (j != i && req_i[j] && older_i[j][i]) gnt_o[i] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/rs_alu_model.sv
`timescale 1ns/1ps
module rs_alu_model import rs_pkg::*; #(
  parameter int DATA_W = 16
) (
  input  rs_op_e            op_i,
  input  logic [DATA_W-1:0] vj_i,
  input  logic [DATA_W-1:0] vk_i,
  input  logic [DATA_W-1:0] a_i,
  output logic [DATA_W-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_SUB:  res_o = vj_i - vk_i;
      OP_MUL:  res_o = vj_i * vk_i;
      OP_DIV:  res_o = (vk_i == '0) ? '1 : vj_i / vk_i;
      OP_ADR:  res_o = vj_i + a_i;
      default: res_o = vj_i + vk_i;
    endcase
  end
endmodule

// File: rtl/rs_entry.sv
`timescale 1ns/1ps
module rs_entry import rs_pkg::*; #(
  parameter int          DATA_W  = 16,
  parameter int          TAG_W   = 4,
  parameter int          CNT_W   = 6,
  parameter int          ADD_LAT = 2,
  parameter int          MUL_LAT = 10,
  parameter int          DIV_LAT = 40,
  parameter int          ADR_LAT = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  rs_op_e            op_i,
  input  logic [DATA_W-1:0] vj_i,
  input  logic [DATA_W-1:0] vk_i,
  input  logic [TAG_W-1:0]  qj_i,
  input  logic [TAG_W-1:0]  qk_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic              bus_valid_i,
  input  logic [TAG_W-1:0]  bus_tag_i,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic              disp_i,
  input  logic              bcast_i,
  output logic              busy_o,
  output logic              ready_o,
  output logic              done_o,
  output rs_op_e            op_o,
  output logic [DATA_W-1:0] vj_o,
  output logic [DATA_W-1:0] vk_o,
  output logic [DATA_W-1:0] a_o
);
  rs_state_e         st_q;
  logic [CNT_W-1:0]  cnt_q, lat;
  rs_op_e            op_q;
  logic [DATA_W-1:0] vj_q, vk_q, a_q;
  logic [TAG_W-1:0]  qj_q, qk_q;
  logic              hit_j, hit_k, new_hit_j, new_hit_k;

  assign hit_j     = bus_valid_i && qj_q != '0 && qj_q == bus_tag_i;
  assign hit_k     = bus_valid_i && qk_q != '0 && qk_q == bus_tag_i;
  assign new_hit_j = bus_valid_i && qj_i != '0 && qj_i == bus_tag_i;
  assign new_hit_k = bus_valid_i && qk_i != '0 && qk_i == bus_tag_i;

  always_comb begin
    unique case (op_q)
      OP_MUL:  lat = CNT_W'(MUL_LAT);
      OP_DIV:  lat = CNT_W'(DIV_LAT);
      OP_ADR:  lat = CNT_W'(ADR_LAT);
      default: lat = CNT_W'(ADD_LAT);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_FREE;
      cnt_q <= '0;
      op_q  <= OP_ADD;
      vj_q  <= '0;
      vk_q  <= '0;
      a_q   <= '0;
      qj_q  <= '0;
      qk_q  <= '0;
    end else begin
      unique case (st_q)
        ST_FREE: if (wr_i) begin
          st_q <= ST_WAIT;
          op_q <= op_i;
          a_q  <= a_i;
          vj_q <= new_hit_j ? bus_data_i : vj_i;
          qj_q <= new_hit_j ? '0 : qj_i;
          vk_q <= new_hit_k ? bus_data_i : vk_i;
          qk_q <= new_hit_k ? '0 : qk_i;
        end
        ST_WAIT: begin
          if (hit_j) begin vj_q <= bus_data_i; qj_q <= '0; end
          if (hit_k) begin vk_q <= bus_data_i; qk_q <= '0; end
          if (disp_i) begin
            st_q  <= (lat <= CNT_W'(1)) ? ST_DONE : ST_EXEC;
            cnt_q <= lat - CNT_W'(1);
          end
        end
        ST_EXEC: begin
          if (cnt_q <= CNT_W'(1)) st_q <= ST_DONE;
          cnt_q <= cnt_q - CNT_W'(1);
        end
        ST_DONE: if (bcast_i) st_q <= ST_FREE;
        default: st_q <= ST_FREE;
      endcase
    end
  end

  assign busy_o  = st_q != ST_FREE;
  assign ready_o = st_q == ST_WAIT && qj_q == '0 && qk_q == '0;
  assign done_o  = st_q == ST_DONE;
  assign op_o    = op_q;
  assign vj_o    = vj_q;
  assign vk_o    = vk_q;
  assign a_o     = a_q;

  AST_DISP_ONLY_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_i |-> ready_o); // R8
  AST_BCAST_ONLY_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bcast_i |-> done_o); // R9
  AST_WAKE_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT && hit_j) |=> (qj_q == '0 && vj_q == $past(bus_data_i))); // R6
  AST_ISSUE_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FREE && wr_i && new_hit_k) |=> (qk_q == '0 && vk_q == $past(bus_data_i))); // R7
  AST_FREE_AFTER_BCAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bcast_i |=> !busy_o); // R10
  AST_TAG0_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT && bus_valid_i && bus_tag_i == '0) |=> $stable(vj_q) && $stable(vk_q)); // R11
endmodule

// File: rtl/rs_array.sv
`timescale 1ns/1ps
module rs_array import rs_pkg::*; #(
  parameter int N_ENT    = 3,
  parameter int DATA_W   = 16,
  parameter int TAG_W    = 4,
  parameter int BASE_TAG = 1,
  parameter int ADD_LAT  = 2,
  parameter int MUL_LAT  = 10,
  parameter int DIV_LAT  = 40,
  parameter int ADR_LAT  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_valid_i,
  input  logic [2:0]        issue_op_i,
  input  logic [DATA_W-1:0] issue_vj_i,
  input  logic [DATA_W-1:0] issue_vk_i,
  input  logic [TAG_W-1:0]  issue_qj_i,
  input  logic [TAG_W-1:0]  issue_qk_i,
  input  logic [DATA_W-1:0] issue_addr_i,
  output logic              issue_ready_o,
  output logic [TAG_W-1:0]  issue_tag_o,
  input  logic              bus_valid_i,
  input  logic [TAG_W-1:0]  bus_tag_i,
  input  logic [DATA_W-1:0] bus_data_i,
  output logic              res_valid_o,
  output logic [TAG_W-1:0]  res_tag_o,
  output logic [DATA_W-1:0] res_data_o
);
  localparam int IDX_W   = (N_ENT > 1) ? $clog2(N_ENT) : 1;
  localparam int LAT_AM  = (ADD_LAT > MUL_LAT) ? ADD_LAT : MUL_LAT;
  localparam int LAT_DA  = (DIV_LAT > ADR_LAT) ? DIV_LAT : ADR_LAT;
  localparam int MAX_LAT = (LAT_AM > LAT_DA) ? LAT_AM : LAT_DA;
  localparam int CNT_W   = $clog2(MAX_LAT + 1);

  logic [N_ENT-1:0]            busy, ready, done, wr, disp_gnt, bc_gnt;
  logic [N_ENT-1:0][N_ENT-1:0] older_q;
  rs_op_e                      op_a [N_ENT];
  logic [DATA_W-1:0]           vj_a [N_ENT], vk_a [N_ENT], a_a [N_ENT];
  logic [IDX_W-1:0]            alloc_idx, bc_idx;
  logic                        do_issue;

  always_comb begin
    alloc_idx = '0;
    for (int i = N_ENT - 1; i >= 0; i--) if (!busy[i]) alloc_idx = IDX_W'(i);
  end

  assign issue_ready_o = ~&busy;
  assign issue_tag_o   = TAG_W'(BASE_TAG) + TAG_W'(alloc_idx);
  assign do_issue      = issue_valid_i && issue_ready_o;

  // age matrix: the new entry is younger than every occupied one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      older_q <= '0;
    end else if (do_issue) begin
      for (int j = 0; j < N_ENT; j++) begin
        older_q[j][alloc_idx] <= busy[j];
        older_q[alloc_idx][j] <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    assign wr[g] = do_issue && alloc_idx == IDX_W'(g);
    rs_entry #(
      .DATA_W(DATA_W), .TAG_W(TAG_W), .CNT_W(CNT_W),
      .ADD_LAT(ADD_LAT), .MUL_LAT(MUL_LAT), .DIV_LAT(DIV_LAT), .ADR_LAT(ADR_LAT)
    ) u_ent (
      .clk_i, .rst_ni,
      .wr_i(wr[g]), .op_i(rs_op_e'(issue_op_i)),
      .vj_i(issue_vj_i), .vk_i(issue_vk_i),
      .qj_i(issue_qj_i), .qk_i(issue_qk_i), .a_i(issue_addr_i),
      .bus_valid_i, .bus_tag_i, .bus_data_i,
      .disp_i(disp_gnt[g]), .bcast_i(bc_gnt[g]),
      .busy_o(busy[g]), .ready_o(ready[g]), .done_o(done[g]),
      .op_o(op_a[g]), .vj_o(vj_a[g]), .vk_o(vk_a[g]), .a_o(a_a[g])
    );
  end

  rs_age_pick #(.N(N_ENT)) u_disp_pick (.req_i(ready), .older_i(older_q), .gnt_o(disp_gnt));
  rs_age_pick #(.N(N_ENT)) u_bc_pick   (.req_i(done),  .older_i(older_q), .gnt_o(bc_gnt));

  always_comb begin
    bc_idx = '0;
    for (int i = 0; i < N_ENT; i++) if (bc_gnt[i]) bc_idx = IDX_W'(i);
  end

  rs_alu_model #(.DATA_W(DATA_W)) u_alu (
    .op_i(op_a[bc_idx]), .vj_i(vj_a[bc_idx]), .vk_i(vk_a[bc_idx]), .a_i(a_a[bc_idx]),
    .res_o(res_data_o)
  );

  assign res_valid_o = |done;
  assign res_tag_o   = TAG_W'(BASE_TAG) + TAG_W'(bc_idx);

  AST_ONE_DISPATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(disp_gnt) && (|ready -> |disp_gnt)); // R8
  AST_ONE_BCAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bc_gnt) && (res_valid_o -> |bc_gnt)); // R9
  AST_FULL_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_i && !issue_ready_o) |=> $countones(busy) <= $past($countones(busy))); // R3
  AST_ISSUE_FILLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (do_issue && !res_valid_o) |=> $countones(busy) == $past($countones(busy)) + 1); // R2
endmodule

// File: tb/rs_array_test.sv
`timescale 1ns/1ps
module rs_array_test;
  localparam int DW = 16;
  localparam int TW = 4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          issue_valid;
  logic [2:0]    issue_op;
  logic [DW-1:0] issue_vj, issue_vk, issue_addr;
  logic [TW-1:0] issue_qj, issue_qk;
  logic          issue_ready;
  logic [TW-1:0] issue_tag;
  logic          res_valid;
  logic [TW-1:0] res_tag;
  logic [DW-1:0] res_data;
  logic          inj_valid;
  logic [TW-1:0] inj_tag;
  logic [DW-1:0] inj_data;
  logic          bus_valid;
  logic [TW-1:0] bus_tag;
  logic [DW-1:0] bus_data;

  always #2.5 clk = ~clk;

  assign bus_valid = res_valid | inj_valid;
  assign bus_tag   = res_valid ? res_tag : inj_tag;
  assign bus_data  = res_valid ? res_data : inj_data;

  rs_array uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .issue_valid_i(issue_valid), .issue_op_i(issue_op),
    .issue_vj_i(issue_vj), .issue_vk_i(issue_vk),
    .issue_qj_i(issue_qj), .issue_qk_i(issue_qk), .issue_addr_i(issue_addr),
    .issue_ready_o(issue_ready), .issue_tag_o(issue_tag),
    .bus_valid_i(bus_valid), .bus_tag_i(bus_tag), .bus_data_i(bus_data),
    .res_valid_o(res_valid), .res_tag_o(res_tag), .res_data_o(res_data)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // op, vj, vk, addr, expected result
  localparam logic [66:0] VEC [8] = '{
    {3'd0, 16'd5,     16'd7,   16'd0,     16'h000C},
    {3'd1, 16'd3,     16'd5,   16'd0,     16'hFFFE},
    {3'd2, 16'd300,   16'd300, 16'd0,     16'h5F90},
    {3'd3, 16'd100,   16'd7,   16'd0,     16'h000E},
    {3'd3, 16'd9,     16'd0,   16'd0,     16'hFFFF},
    {3'd4, 16'h1000,  16'd5,   16'h0022,  16'h1022},
    {3'd2, 16'hFFFF,  16'd2,   16'd0,     16'hFFFE},
    {3'd0, 16'hFFFF,  16'd1,   16'd0,     16'h0000}
  };

  function automatic int lat_of(input logic [2:0] op);
    case (op)
      3'd2:    return 10;
      3'd3:    return 40;
      3'd4:    return 1;
      default: return 2;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    issue_valid = 1'b0;
    inj_valid   = 1'b0;
  endtask

  task automatic issue(input logic [2:0] op, input logic [DW-1:0] vj, input logic [DW-1:0] vk,
                       input logic [TW-1:0] qj, input logic [TW-1:0] qk, input logic [DW-1:0] a);
    issue_valid = 1'b1;
    issue_op    = op;
    issue_vj    = vj;
    issue_vk    = vk;
    issue_qj    = qj;
    issue_qk    = qk;
    issue_addr  = a;
  endtask

  task automatic inject(input logic [TW-1:0] t, input logic [DW-1:0] d);
    inj_valid = 1'b1;
    inj_tag   = t;
    inj_data  = d;
  endtask

  task automatic chk_bus(input string req, input bit ev, input logic [TW-1:0] et, input logic [DW-1:0] ed);
    if (ev) chk(req, {11'd0, res_valid, res_tag, res_data}, {11'd0, 1'b1, et, ed});
    else    chk(req, {31'd0, res_valid}, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle();
    issue_op = '0; issue_vj = '0; issue_vk = '0; issue_qj = '0; issue_qk = '0; issue_addr = '0;
    inj_tag = '0; inj_data = '0;
    repeat (3) step();
    rst_ni = 1'b1;
    step();

    // R1 reset state
    chk("R1 ready", {31'd0, issue_ready}, 32'd1);
    chk("R1 tag",   {28'd0, issue_tag}, 32'd1);
    chk("R1 bus",   {31'd0, res_valid}, 32'd0);

    // table: independent operands, one at a time (R4, R5, R2)
    for (int v = 0; v < 8; v++) begin
      logic [2:0] op;
      int cyc;
      op = VEC[v][66:64];
      issue(op, VEC[v][63:48], VEC[v][47:32], '0, '0, VEC[v][31:16]);
      step();
      idle();
      cyc = 1;
      while (!res_valid && cyc < 100) begin
        step();
        cyc++;
      end
      chk("R4 latency", cyc, lat_of(op) + 1);
      chk("R5 result",  {16'd0, res_data}, {16'd0, VEC[v][15:0]});
      chk("R2 tag",     {28'd0, res_tag}, 32'd1);
      step();
    end

    // dependency chain, issue-time capture, full array
    for (int k = 0; k < 12; k++) begin
      bit ev;
      logic [TW-1:0] et;
      logic [DW-1:0] ed;
      idle();
      ev = 0; et = '0; ed = '0;
      case (k)
        0: begin chk("R2 tag e0", {28'd0, issue_tag}, 32'd1); issue(3'd0, 16'd0, 16'd4, 4'd9, 4'd0, 16'd0); end
        1: begin chk("R2 tag e1", {28'd0, issue_tag}, 32'd2); issue(3'd1, 16'd0, 16'd10, 4'd1, 4'd0, 16'd0); end
        2: begin
          chk("R2 tag e2", {28'd0, issue_tag}, 32'd3);
          issue(3'd0, 16'd0, 16'd1, 4'd9, 4'd0, 16'd0);
          inject(4'd9, 16'd20);   // R7 same-cycle capture for this issue
        end
        3: begin chk("R3 full", {31'd0, issue_ready}, 32'd0); issue(3'd0, 16'd1, 16'd1, 4'd0, 4'd0, 16'd0); end
        5: begin ev = 1; et = 4'd1; ed = 16'd24; end
        6: begin
          ev = 1; et = 4'd3; ed = 16'd21;
          chk("R10 ready", {31'd0, issue_ready}, 32'd1);
          chk("R10 tag",   {28'd0, issue_tag}, 32'd1);
        end
        8: begin ev = 1; et = 4'd2; ed = 16'd14; end
        default: ;
      endcase
      if (k == 6)      chk_bus("R7 bus", ev, et, ed);
      else if (k == 8) chk_bus("R6 bus", ev, et, ed);
      else             chk_bus("R3 bus", ev, et, ed);
      step();
    end

    // age order differs from index order; tag-0 bus
    for (int k = 0; k < 12; k++) begin
      bit ev;
      logic [TW-1:0] et;
      logic [DW-1:0] ed;
      idle();
      ev = 0; et = '0; ed = '0;
      case (k)
        0: issue(3'd0, 16'd1, 16'd2, 4'd0, 4'd0, 16'd0);
        1: begin chk("R2 tag e1", {28'd0, issue_tag}, 32'd2); issue(3'd0, 16'd0, 16'd5, 4'd9, 4'd0, 16'd0); end
        2: inject(4'd0, 16'h0AAA);
        3: begin ev = 1; et = 4'd1; ed = 16'd3; end
        4: begin chk("R10 reuse", {28'd0, issue_tag}, 32'd1); issue(3'd4, 16'd0, 16'd0, 4'd9, 4'd0, 16'h0010); end
        5: inject(4'd9, 16'd100);
        8: begin ev = 1; et = 4'd2; ed = 16'd105; end
        9: begin ev = 1; et = 4'd1; ed = 16'd116; end
        default: ;
      endcase
      if (k == 8)      chk_bus("R8 R11 bus", ev, et, ed);
      else if (k == 9) chk_bus("R9 bus", ev, et, ed);
      else             chk_bus("R9 idle", ev, et, ed);
      step();
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule